// File: doc/BRIEF.md
# Network MAC Interrupt Aggregator

This block gathers the event pulses of a network MAC into one level interrupt for the host processor. Each of seven event inputs sets its own sticky bit in a cause register. A separate enable register selects which causes may raise the interrupt line. The cause bits latch whether or not they are enabled. Software therefore finds the pending, enabled causes by reading both registers and combining them with AND. Software then clears the causes it has handled by writing ones to them.

Both registers sit on a simple 32-bit register bus. The bus has an address, a write enable, write data and combinational read data. Only the low seven bits of each register are implemented. Driver code changes the enable register by read-modify-write, so that register returns exactly the implemented bits that were last written. The interrupt output is registered, so it follows the cause and enable state with one clock of delay.

Top module: `mac_irq_ctrl`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), the cause register, the enable register and `irq` are all zero.
- R2: An `evt` pulse on bit i sets cause bit i at the next clock edge, even when enable bit i is zero. Bit meanings: 0 transmit frame done, 1 transmit error, 2 frame received, 3 receive error, 4 frame dropped while busy, 5 transmit control frame, 6 receive control frame.
- R3: A write to the cause register (address 0x04) clears every cause bit whose write-data bit is one. Cause bits whose write-data bit is zero keep their value.
- R4: A write to the enable register (address 0x08) stores write-data bits 6:0. A read of address 0x08 returns exactly those bits.
- R5: `irq` is high in the cycle after a clock edge at which (cause AND enable) was nonzero. It is low in the cycle after an edge at which that value was zero.
- R6: If an event pulse and a write-one-to-clear hit the same cause bit in the same cycle, the bit is set after that edge.
- R7: Bits 31:7 of both registers read as zero, and writes to them have no effect. Any other address reads as zero, and writes to it change neither register.
- R8: A write to the enable register leaves the cause register unchanged. A write to the cause register leaves the enable register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt | input | 7 | Single-cycle event pulses, one per cause bit |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Registered level interrupt |

## Verification
A wrong cause bit shows at `rdData` in the first cycle after the faulty edge, provided the address selects the cause register. It also shows at `irq` one cycle after that, whenever the bit is enabled. The bench keeps the read address on the cause or enable register through most phases, so a lost event, a missed or excess clear, or a corrupted enable bit is visible within one or two cycles. The event-against-clear collision and the writes to unimplemented bits and to other addresses are each driven on purpose. Each is followed at once by a read of the register it could have disturbed.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
  typedef struct packed {
    logic clrSrc;
    logic wrMask;
    logic rdSrc;
    logic rdMask;
  } regStrobe_t;
endpackage

// File: rtl/mac_irq_ctrl_decode.sv
module mac_irq_ctrl_decode
  import mac_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SRC_OFF  = 8'h04,
  parameter logic [ADDR_W-1:0] MASK_OFF = 8'h08
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output regStrobe_t        strb
);
  logic hitSrc;
  logic hitMask;

  assign hitSrc  = (addr == SRC_OFF);
  assign hitMask = (addr == MASK_OFF);

  always_comb begin
    strb.clrSrc = wrEn & hitSrc;
    strb.wrMask = wrEn & hitMask;
    strb.rdSrc  = hitSrc;
    strb.rdMask = hitMask;
  end
endmodule

// File: rtl/mac_irq_ctrl_regs.sv
module mac_irq_ctrl_regs
  import mac_irq_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  regStrobe_t         strb,
  input  logic [NUM_SRC-1:0] evt,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  srcQ,
  output logic [DATA_W-1:0]  maskQ,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq
);
  localparam int PAD_W = DATA_W - NUM_SRC;
  localparam logic [DATA_W-1:0] IMPL = {{PAD_W{1'b0}}, {NUM_SRC{1'b1}}};

  logic [DATA_W-1:0] clrVec;
  logic [DATA_W-1:0] setVec;
  logic [DATA_W-1:0] srcNext;
  logic [DATA_W-1:0] maskNext;

  assign clrVec   = strb.clrSrc ? (wrData & IMPL) : '0;
  assign setVec   = {{PAD_W{1'b0}}, evt};
  // set dominates clear so that a colliding event is not lost
  assign srcNext  = (setVec | (srcQ & ~clrVec)) & IMPL;
  assign maskNext = strb.wrMask ? (wrData & IMPL) : maskQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      srcQ  <= '0;
      maskQ <= '0;
      irq   <= 1'b0;
    end else begin
      srcQ  <= srcNext;
      maskQ <= maskNext;
      irq   <= |(srcQ & maskQ);
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.rdSrc)       rdData = srcQ;
    else if (strb.rdMask) rdData = maskQ;
  end
endmodule

// File: rtl/mac_irq_ctrl.sv
module mac_irq_ctrl
  import mac_irq_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] SRC_OFF  = 8'h04,
  parameter logic [ADDR_W-1:0] MASK_OFF = 8'h08
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq
);
  regStrobe_t        strb;
  logic [DATA_W-1:0] srcQ;
  logic [DATA_W-1:0] maskQ;

  mac_irq_ctrl_decode #(
    .ADDR_W(ADDR_W), .SRC_OFF(SRC_OFF), .MASK_OFF(MASK_OFF)
  ) u_decode (
    .addr(addr), .wrEn(wrEn), .strb(strb)
  );

  mac_irq_ctrl_regs #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .strb(strb), .evt(evt), .wrData(wrData),
    .srcQ(srcQ), .maskQ(maskQ), .rdData(rdData), .irq(irq)
  );
endmodule

// File: rtl/mac_irq_ctrl_chk.sv
module mac_irq_ctrl_chk #(
  parameter int NUM_SRC = 7,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] SRC_OFF  = 8'h04,
  parameter logic [ADDR_W-1:0] MASK_OFF = 8'h08
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] evt,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wrData,
  input logic [DATA_W-1:0]  rdData,
  input logic               irq,
  input logic [DATA_W-1:0]  srcQ,
  input logic [DATA_W-1:0]  maskQ
);
  logic [NUM_SRC-1:0] srcLo;
  logic [NUM_SRC-1:0] maskLo;
  logic [NUM_SRC-1:0] wdLo;
  assign srcLo  = srcQ[NUM_SRC-1:0];
  assign maskLo = maskQ[NUM_SRC-1:0];
  assign wdLo   = wrData[NUM_SRC-1:0];

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (srcQ == '0 && maskQ == '0 && !irq));

  // R2, R6
  a_r2_event_latches: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((srcLo & $past(evt)) == $past(evt)));

  a_r3_clear_ones: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == SRC_OFF) |=> ((srcLo & $past(wdLo & ~evt)) == '0));

  a_r4_mask_readback: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == MASK_OFF) |=> (maskLo == $past(wdLo)));

  a_r5_irq_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past((srcQ & maskQ) != '0));

  a_r5_irq_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past((srcQ & maskQ) == '0));

  a_r7_other_addr_zero: assert property (@(posedge clk) disable iff (rst)
    (addr != SRC_OFF && addr != MASK_OFF) |-> (rdData == '0));

  a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (rdData[DATA_W-1:NUM_SRC] == '0));

  a_r8_mask_holds: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && addr == MASK_OFF) |=> $stable(maskQ));
endmodule

bind mac_irq_ctrl mac_irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .SRC_OFF(SRC_OFF), .MASK_OFF(MASK_OFF)
) u_chk (
  .clk(clk), .rst(rst), .evt(evt), .wrEn(wrEn), .addr(addr),
  .wrData(wrData), .rdData(rdData), .irq(irq), .srcQ(srcQ), .maskQ(maskQ)
);

// File: tb/mac_irq_ctrl_bench.sv
`timescale 1ns/1ps
module mac_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  evt = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = 8'h04;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int checks = 0;
  int failures = 0;
  string curReq = "R1";
  bit done = 0;

  // behavioural reference state
  int unsigned mSrc = 0;
  int unsigned mMask = 0;
  bit mIrq = 0;

  always #2 clk = ~clk;

  mac_irq_ctrl u_mac_irq_ctrl (
    .clk(clk), .rst(rst), .evt(evt), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  function automatic int unsigned expRead(input logic [7:0] a);
    if (a == 8'h04) return mSrc;
    if (a == 8'h08) return mMask;
    return 0;
  endfunction

  task automatic check(input string req, input int unsigned act, input int unsigned exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit nIrq;
    int unsigned clr;
    if (rst) begin
      mSrc = 0; mMask = 0; mIrq = 0;
    end else begin
      nIrq = ((mSrc & mMask) != 0);
      clr = (wrEn && addr == 8'h04) ? (wrData & 32'h7F) : 0;
      mSrc = (mSrc & ~clr) | {25'd0, evt};
      if (wrEn && addr == 8'h08) mMask = wrData & 32'h7F;
      mIrq = nIrq;
    end
    #1;
    if (!done) begin
      check(curReq, {31'd0, irq}, {31'd0, mIrq}, "irq");
      check(curReq, rdData, expRead(addr), "rdData");
    end
  end

  task automatic step(input logic [6:0] e, input logic we, input logic [7:0] a, input logic [31:0] d);
    evt = e; wrEn = we; addr = a; wrData = d;
    @(negedge clk);
    evt = '0; wrEn = 1'b0;
  endtask

  task automatic idle(input logic [7:0] a, input int n);
    for (int i = 0; i < n; i++) step('0, 1'b0, a, '0);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    curReq = "R1";
    check("R1", rdData, 0, "cause after reset");
    addr = 8'h08; #0.1;
    check("R1", rdData, 0, "enable after reset");
    check("R1", {31'd0, irq}, 0, "irq after reset");

    curReq = "R2";
    for (int b = 0; b < 7; b++) begin
      step(7'(1 << b), 1'b0, 8'h04, '0);
      check("R2", rdData, (2 << b) - 1, "cause accumulates while disabled");
    end
    idle(8'h04, 2);
    check("R2", {31'd0, irq}, 0, "irq stays low with enable zero");

    curReq = "R3";
    step('0, 1'b1, 8'h04, 32'h05);
    check("R3", rdData, 32'h7A, "partial clear");
    step('0, 1'b1, 8'h04, 32'h00);
    check("R3", rdData, 32'h7A, "write zero keeps bits");
    step('0, 1'b1, 8'h04, 32'h7A);
    check("R3", rdData, 0, "full clear");

    curReq = "R4";
    step('0, 1'b1, 8'h08, 32'h55);
    check("R4", rdData, 32'h55, "enable readback");
    step('0, 1'b1, 8'h08, 32'h2A);
    check("R4", rdData, 32'h2A, "enable readback second pattern");

    curReq = "R5";
    step('0, 1'b1, 8'h08, 32'h01);
    step(7'h08, 1'b0, 8'h04, '0);
    idle(8'h04, 2);
    check("R5", {31'd0, irq}, 0, "disabled cause raises nothing");
    step(7'h01, 1'b0, 8'h04, '0);
    check("R5", {31'd0, irq}, 0, "irq one cycle after cause");
    step('0, 1'b0, 8'h04, '0);
    check("R5", {31'd0, irq}, 1, "irq asserted");
    step('0, 1'b1, 8'h04, 32'h01);
    step('0, 1'b0, 8'h04, '0);
    check("R5", {31'd0, irq}, 0, "irq drops after clear");
    step('0, 1'b1, 8'h08, 32'h08);
    step('0, 1'b0, 8'h04, '0);
    check("R5", {31'd0, irq}, 1, "late enable of pending cause");
    step('0, 1'b1, 8'h08, 32'h00);
    step('0, 1'b0, 8'h04, '0);
    check("R5", {31'd0, irq}, 0, "disabling drops irq");

    curReq = "R6";
    step(7'h10, 1'b1, 8'h04, 32'h7F);
    check("R6", rdData, 32'h10, "event wins over clear");
    step('0, 1'b1, 8'h04, 32'h10);

    curReq = "R7";
    step('0, 1'b1, 8'h08, 32'hFFFF_FFFF);
    check("R7", rdData, 32'h7F, "upper enable bits read zero");
    step(7'h03, 1'b0, 8'h04, '0);
    step('0, 1'b1, 8'h0C, 32'hFFFF_FFFF);
    check("R7", rdData, 0, "unmapped address reads zero");
    step('0, 1'b1, 8'h00, 32'hFFFF_FFFF);
    addr = 8'h04; #0.1;
    check("R7", rdData, 32'h03, "cause untouched by unmapped writes");
    addr = 8'h08; #0.1;
    check("R7", rdData, 32'h7F, "enable untouched by unmapped writes");

    curReq = "R8";
    step('0, 1'b1, 8'h08, 32'h40);
    addr = 8'h04; #0.1;
    check("R8", rdData, 32'h03, "enable write keeps cause");
    step('0, 1'b1, 8'h04, 32'h03);
    addr = 8'h08; #0.1;
    check("R8", rdData, 32'h40, "cause write keeps enable");
    idle(8'h08, 3);

    curReq = "R1";
    rst = 1'b1;
    idle(8'h04, 2);
    rst = 1'b0;
    step('0, 1'b0, 8'h08, '0);
    check("R1", rdData, 0, "enable after second reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired in %s", curReq);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule